// File: doc/BRIEF.md
# Daisy-Chainable 16-bit Serial Slave

This block is the serial front end of a device that is driven by a host over a four-wire SPI link in mode 0. When chip select goes low, it loads a 16-bit status word into its shift register and sends that word out MSB first, while the host shifts a new 16-bit command in. The status word comes from one of four input words. Which word is sent is set by a selector that an earlier initialisation command stored. After the first 16 clocks, the serial output repeats the serial input 16 bit times later. A host can therefore chain several slaves and clock a frame of 16·N bits through all of them.

When chip select rises, the block checks the number of clocks in the frame. It accepts the frame only when that count is a nonzero multiple of 16. For an accepted frame, it presents the last 16 bits received as a 5-bit address and an 11-bit data field, with a one-cycle strobe. In the same cycle it pulses a read-done signal that carries the selector used for the status word, so that the neighbouring status logic can clear the bits it reported. A rejected frame leaves no trace: no strobe, no read-done pulse, and no change to the selector. SCLK, CS and SI are synchronised to the system clock, which must run at least 4 times faster than SCLK. The output-enable tells the pad when to drive SO and when to leave it high-impedance.

Top module: `spi_chain_slave`

## Requirements
- R1: After reset, so_oe_o, so_o, cmd_valid_o and rd_done_o are low and the stored selector is 0, so the first frame returns status word 0.
- R2: When CS falls, status word `status_i[16*sel +: 16]` is loaded, and its bit 15 is on so_o before the first rising SCLK edge.
- R3: During the first 16 SCLK periods, so_o gives status bits 15 down to 0, one per period. so_o changes after a falling SCLK edge and is stable at the next rising edge.
- R4: Frame bit k, for k ≥ 16, on so_o equals the SI bit sampled at rising edge k−16 of the same frame.
- R5: At the end of a frame whose count of rising SCLK edges is a nonzero multiple of 16, cmd_valid_o pulses high for exactly one cycle. It presents cmd_addr_o = bits [15:11] and cmd_data_o = bits [10:0] of the last 16 SI bits, with the first of those 16 bits as bit 15.
- R6: A frame with zero edges, or with an edge count that is not a multiple of 16, produces no cmd_valid_o pulse and no rd_done_o pulse, and leaves the selector unchanged.
- R7: A valid frame whose address equals INIT_ADDR (0) sets the selector to cmd_data_o[1:0], starting with the next frame.
- R8: so_oe_o is high while CS is low, allowing for the synchroniser delay. It is low within a few cycles after CS rises, and so_o is 0 while so_oe_o is low.
- R9: rd_done_o pulses together with cmd_valid_o. rd_sel_o gives the selector that chose this frame's status word.
- R10: Frames of 32 or 48 edges are valid and commit their last 16 bits. A 33-edge frame is rejected: the edge counter never wraps into a false valid result.
- R11: cmd_valid_o is only asserted after CS has risen, never while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| status_i | input | 64 | Four 16-bit status words, word n at [16n+15:16n] |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Pad output enable for SO (low = high-impedance) |
| cmd_valid_o | output | 1 | One-cycle commit strobe |
| cmd_addr_o | output | 5 | Committed address |
| cmd_data_o | output | 11 | Committed data |
| rd_done_o | output | 1 | Status word of the committed frame was read |
| rd_sel_o | output | 2 | Selector used for that status word |

## Verification
On every cycle, assertions check the following: the commit strobe lasts a single cycle and only follows a synchronised CS rise; the selector holds when there is no commit; the first status bit reaches SO one cycle after the load; and SO stays quiet while it is not enabled. Only the bench scenarios can show the bit order on SO, the 16-bit echo delay, and the chosen address and data. They also show that a rejected frame (zero, 12, 20 or 33 edges) leaves no trace and that the selector switch takes effect on the following frame.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = WORD_W - ADDR_W;
  localparam int SEL_W    = 2;
  localparam int NUM_STAT = 1 << SEL_W;
  localparam int CNT_W    = $clog2(WORD_W);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/spi_chain_sync.sv
module spi_chain_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= q_o;
  end

  assign rise_o = q_o & ~prev_q;
  assign fall_o = ~q_o & prev_q;
endmodule

// File: rtl/spi_chain_shifter.sv
module spi_chain_shifter
  import spi_chain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              drive_i,
  input  logic              idle_i,
  input  logic              si_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] shreg_o,
  output logic              so_o
);
  logic [WORD_W-1:0] shreg_q;
  logic              so_q;

  // the register doubles as the 16-bit echo delay line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
    end else if (load_i) begin
      shreg_q <= word_i;
    end else if (shift_i) begin
      shreg_q <= {shreg_q[WORD_W-2:0], si_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      so_q <= 1'b0;
    else if (load_i)  so_q <= word_i[WORD_W-1];
    else if (idle_i)  so_q <= 1'b0;
    else if (drive_i) so_q <= shreg_q[WORD_W-1];
  end

  assign shreg_o = shreg_q;
  assign so_o    = so_q;

  assert_load_msb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> so_o == $past(word_i[WORD_W-1]));
endmodule

// File: rtl/spi_chain_frame_ctl.sv
module spi_chain_frame_ctl
  import spi_chain_pkg::*;
#(
  parameter logic [ADDR_W-1:0] INIT_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              bit_i,
  input  logic [WORD_W-1:0] last_word_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              cmd_valid_o,
  output cmd_t              cmd_o,
  output logic              rd_done_o,
  output logic [SEL_W-1:0]  rd_sel_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic [SEL_W-1:0] sel_q, frame_sel_q, rd_sel_q;
  logic             commit, valid_q;
  cmd_t             cmd_q, rx_cmd;

  assign rx_cmd = cmd_t'(last_word_i);

  // modulo counter plus a sticky "any edge" flag: no wrap to a false valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      frame_sel_q <= '0;
    end else if (cs_fall_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      frame_sel_q <= sel_q;
    end else if (bit_i) begin
      cnt_q  <= cnt_q + 1'b1;
      seen_q <= 1'b1;
    end
  end

  assign commit = cs_rise_i && seen_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      cmd_q    <= '0;
      rd_sel_q <= '0;
      sel_q    <= '0;
    end else begin
      valid_q <= commit;
      if (commit) begin
        cmd_q    <= rx_cmd;
        rd_sel_q <= frame_sel_q;
        if (rx_cmd.addr == INIT_ADDR) sel_q <= rx_cmd.data[SEL_W-1:0];
      end
    end
  end

  assign sel_o       = sel_q;
  assign cmd_valid_o = valid_q;
  assign cmd_o       = cmd_q;
  assign rd_done_o   = valid_q;
  assign rd_sel_o    = rd_sel_q;

  assert_commit_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_commit_after_cs_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(cs_rise_i));
  assert_sel_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> sel_q == $past(sel_q));
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] INIT_ADDR = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       cs_ni,
  input  logic                       si_i,
  input  logic [NUM_STAT*WORD_W-1:0] status_i,
  output logic                       so_o,
  output logic                       so_oe_o,
  output logic                       cmd_valid_o,
  output logic [ADDR_W-1:0]          cmd_addr_o,
  output logic [DATA_W-1:0]          cmd_data_o,
  output logic                       rd_done_o,
  output logic [SEL_W-1:0]           rd_sel_o
);
  localparam int IDX_SCLK = 0;
  localparam int IDX_CS   = 1;
  localparam int IDX_SI   = 2;

  logic [2:0] pin_q, pin_rise, pin_fall;
  logic       active, cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [SEL_W-1:0]  sel;
  logic [WORD_W-1:0] shreg, stat_word;
  cmd_t              cmd;

  spi_chain_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni,
    .d_i    ({si_i, cs_ni, sclk_i}),
    .q_o    (pin_q),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign active    = !pin_q[IDX_CS];
  assign cs_fall   = pin_fall[IDX_CS];
  assign cs_rise   = pin_rise[IDX_CS];
  assign sclk_rise = pin_rise[IDX_SCLK] && active;
  assign sclk_fall = pin_fall[IDX_SCLK] && active;
  assign stat_word = status_i[sel*WORD_W +: WORD_W];

  spi_chain_shifter u_shift (
    .clk_i, .rst_ni,
    .load_i  (cs_fall),
    .shift_i (sclk_rise),
    .drive_i (sclk_fall),
    .idle_i  (!active),
    .si_i    (pin_q[IDX_SI]),
    .word_i  (stat_word),
    .shreg_o (shreg),
    .so_o    (so_o)
  );

  spi_chain_frame_ctl #(.INIT_ADDR(INIT_ADDR)) u_ctl (
    .clk_i, .rst_ni,
    .cs_fall_i   (cs_fall),
    .cs_rise_i   (cs_rise),
    .bit_i       (sclk_rise),
    .last_word_i (shreg),
    .sel_o       (sel),
    .cmd_valid_o (cmd_valid_o),
    .cmd_o       (cmd),
    .rd_done_o   (rd_done_o),
    .rd_sel_o    (rd_sel_o)
  );

  assign so_oe_o    = active;
  assign cmd_addr_o = cmd.addr;
  assign cmd_data_o = cmd.data;

  assert_so_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!so_oe_o && $past(!so_oe_o)) |-> !so_o);
endmodule

// File: tb/tb_spi_chain_slave.sv
module tb_spi_chain_slave;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic [63:0] status;
  logic so, so_oe, cmd_valid, rd_done;
  logic [4:0] cmd_addr;
  logic [10:0] cmd_data;
  logic [1:0] rd_sel;

  int total = 0, bad = 0;
  bit done = 0;
  logic exp_so[$];
  logic [17:0] exp_cmd[$];
  logic [1:0] sel_m = 2'd0;

  always #2 clk = ~clk;

  spi_chain_slave dut (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .cs_ni(cs_n), .si_i(si),
    .status_i(status), .so_o(so), .so_oe_o(so_oe),
    .cmd_valid_o(cmd_valid), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
    .rd_done_o(rd_done), .rd_sel_o(rd_sel)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // SO monitor: R2/R3/R4
  always @(posedge sclk) if (!cs_n) begin
    if (exp_so.size() == 0) check("R3 extra bit", 1, 0);
    else check("R2/R3/R4 so bit", {31'd0, so}, {31'd0, exp_so.pop_front()});
  end

  // commit monitor: R5/R6/R9/R11
  always @(negedge clk) if (rst_ni && cmd_valid) begin
    check("R11 commit with cs high", {31'd0, cs_n}, 1);
    check("R9 rd_done with commit", {31'd0, rd_done}, 1);
    if (exp_cmd.size() == 0) check("R6 unexpected commit", 1, 0);
    else check("R5/R9 commit", {14'd0, rd_sel, cmd_addr, cmd_data}, {14'd0, exp_cmd.pop_front()});
  end

  task automatic send(int n, logic [63:0] v);
    for (int i = 0; i < n; i++)
      exp_so.push_back(i < 16 ? status[16*sel_m + 15 - i] : v[n - 1 - (i - 16)]);
    if (n > 0 && n % 16 == 0) begin
      exp_cmd.push_back({sel_m, v[15:0]});
      if (v[15:11] == 5'd0) sel_m = v[1:0];
    end
    @(negedge clk);
    cs_n = 1'b0;
    si = (n > 0) ? v[n-1] : 1'b0;
    repeat (8) @(negedge clk);
    check("R8 oe during frame", {31'd0, so_oe}, 1);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      si = (i + 1 < n) ? v[n - 2 - i] : 1'b0;
      repeat (8) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    check("R8 oe after frame", {31'd0, so_oe}, 0);
    check("R8 so quiet", {31'd0, so}, 0);
    check("R5 commit count", exp_cmd.size(), 0);
    check("R3 bits consumed", exp_so.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check("watchdog", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    status = {16'h8001, 16'h0F0F, 16'h2400, 16'hA5C3};
    repeat (3) @(negedge clk);
    check("R1 oe reset", {31'd0, so_oe}, 0);
    check("R1 so reset", {31'd0, so}, 0);
    check("R1 cmd reset", {30'd0, cmd_valid, rd_done}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 cmd after reset", {31'd0, cmd_valid}, 0);
    send(16, 64'h2923);              // R1 word0, R5 write addr 5
    send(16, 64'h0002);              // R7 init: sel -> 2
    send(16, 64'h4ABC);              // status word2
    send(32, 64'h1234_3BEE);         // R4 echo, R10 32 edges
    send(12, 64'h0FFF);              // R6 short
    send(20, 64'hF_0003);            // R6 init attempt ignored
    send(0, 64'h0);                  // R6 zero edges
    send(33, 64'h1_5555_0001);       // R10 no wrap
    send(48, 64'hCAFE_F00D_0001);    // R10 valid, R7 sel -> 1
    send(16, 64'h7FFF);              // status word1 (bits 13,10)
    send(16, 64'h0003);              // R7 sel -> 3
    send(17, 64'h1_0000);            // R6 invalid, word3 read
    send(16, 64'hFFFF);              // still word3
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule